// File: doc/BRIEF.md
# PLL dynamic update latch controller

This block sits on the register side of a fractional PLL. It lets software move the PLL to a new integer multiplier (L) and fractional word (alpha) without stopping the oscillator. Software first writes the new words into staging registers, which drive the PLL's frequency inputs. It then sets an update request bit in the mode register. The block turns that request into a latch strobe to the PLL. It waits for the PLL's latch acknowledge, copies the staged words into the active-word registers, and returns to idle once the acknowledge has dropped again.

By default the hardware clears the request as soon as it sees the acknowledge. When the bypass bit is set, the strobe stays high until software writes the request back to 0. The acknowledge comes from the analog domain, so it is synchronized before any decision uses it. A programmable timeout aborts a handshake that stalls and records the abort in a sticky error bit. No handshake starts unless the PLL is running and the dynamic-update capability strap is set. In that case a write only changes the staged words.

The register bus is a plain single-cycle write port with a combinational read mux. It has no back-pressure: every write is accepted in the cycle it is presented.

Top module: `pll_retune_ctrl`

## Requirements
- R1: After reset:
  - the mode register reads 0;
  - the staged and active words read 0;
  - the timeout register reads TMO_RST (64);
  - `pll_latch` is low.
- R2: The register addresses are:
  - mode at 0;
  - staged L at 1;
  - staged alpha at 2;
  - active L at 3 (read-only);
  - active alpha at 4 (read-only);
  - timeout limit at 5.

  Staged words read back what was written, zero-extended, and `pll_l`/`pll_alpha` always show the staged words.
- R3: A mode write with bit 22 set starts a handshake only in idle, with `pll_run` and `dyn_cap` both high. Otherwise `pll_latch` stays low, bit 22 reads 0 and the active words do not change.
- R4: `pll_latch` (mode bit 22) is high from the clock edge that accepts the start. The acknowledge is not acted on during the first MIN_WAIT (2) cycles after that edge, and the active words do not change in that window.
- R5: With bypass (mode bit 23) at 0, when the synchronized acknowledge is seen high, the staged words are copied into the active words. The request bit and `pll_latch` clear on that same edge.
- R6: With bypass at 1, after the acknowledge, the request bit and `pll_latch` stay high until software writes the mode register with bit 22 at 0. Mode bit 29 reads the synchronized acknowledge.
- R7: The block returns to idle only after the synchronized acknowledge is low. A start is refused while the synchronized acknowledge is high.
- R8: The acknowledge is checked over the cycles set by the timeout register:
  - If it is not seen high within that many cycles, or not seen low within that many cycles after the request drops, mode bit 24 sets.
  - On that timeout the request clears, the block goes idle and the active words are kept.
  - An acknowledge seen on the last counted cycle wins over the timeout.
  - Writing 1 to bit 24 clears it.
- R9: Writes to the staged words are ignored while a handshake is in progress, so `pll_l` and `pll_alpha` are stable until the handshake ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, also used as the PLL reference cycle count |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pll_run | input | 1 | PLL is enabled and running |
| dyn_cap | input | 1 | Strap: this PLL supports dynamic update |
| pll_ack | input | 1 | Latch acknowledge from the PLL, asynchronous |
| pll_latch | output | 1 | Latch strobe to the PLL |
| pll_l | output | L_W | Staged integer word presented to the PLL |
| pll_alpha | output | A_W | Staged fractional word presented to the PLL |

## Verification
The two functions that can fall in the same cycle are the acknowledge detection and the timeout expiry. Both are evaluated in the acknowledge-wait state on the same counter edge.

The bench programs a small timeout and sweeps the PLL responder's rise delay from 0 to two past the limit, in both bypass settings. A delay of one less than the limit puts the synchronized acknowledge on the very edge where the counter expires. That case must end as a clean update with no error bit. The next delay must end as a timeout that keeps the old active words. The expected outcome of each delay follows from the two-flop synchronizer, the fixed minimum wait and the counter.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;
  localparam int DW     = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADDR_MODE  = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_STG_L = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_STG_A = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_ACT_L = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_ACT_A = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_TMO   = 3'd5;

  localparam int BIT_REQ = 22;
  localparam int BIT_BYP = 23;
  localparam int BIT_ERR = 24;
  localparam int BIT_ACK = 29;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_MIN,
    ST_ACK_SET,
    ST_REQ_CLR,
    ST_ACK_CLR
  } upd_state_e;
endpackage

// File: rtl/pll_ack_sync.sv
module pll_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pll_retune_fsm.sv
module pll_retune_fsm import pll_retune_pkg::*; #(
  parameter int TMO_W    = 8,
  parameter int MIN_WAIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             clr_req,
  input  logic             run_ok,
  input  logic             bypass,
  input  logic             ack_s,
  input  logic [TMO_W-1:0] tmo_lim,
  output upd_state_e       state,
  output logic             req_q,
  output logic             commit,
  output logic             tmo_hit,
  output logic             busy
);
  localparam logic [TMO_W-1:0] MIN_LAST = TMO_W'(MIN_WAIT - 1);

  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] lim_last;

  assign lim_last = tmo_lim - TMO_W'(1);
  assign busy     = (state != ST_IDLE);

  // Acknowledge has priority over expiry on the same counter edge.
  always_comb begin
    commit  = (state == ST_ACK_SET) && ack_s;
    tmo_hit = ((state == ST_ACK_SET) && !ack_s && (cnt == lim_last)) ||
              ((state == ST_ACK_CLR) &&  ack_s && (cnt == lim_last));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req && run_ok && !ack_s) begin
            state <= ST_WAIT_MIN;
            cnt   <= '0;
            req_q <= 1'b1;
          end
        end
        ST_WAIT_MIN: begin
          if (cnt == MIN_LAST) begin
            state <= ST_ACK_SET;
            cnt   <= '0;
          end else begin
            cnt <= cnt + TMO_W'(1);
          end
        end
        ST_ACK_SET: begin
          if (commit) begin
            cnt <= '0;
            if (bypass) begin
              state <= ST_REQ_CLR;
            end else begin
              state <= ST_ACK_CLR;
              req_q <= 1'b0;
            end
          end else if (tmo_hit) begin
            state <= ST_IDLE;
            req_q <= 1'b0;
          end else begin
            cnt <= cnt + TMO_W'(1);
          end
        end
        ST_REQ_CLR: begin
          if (clr_req) begin
            state <= ST_ACK_CLR;
            req_q <= 1'b0;
            cnt   <= '0;
          end
        end
        ST_ACK_CLR: begin
          if (!ack_s || tmo_hit) state <= ST_IDLE;
          else                   cnt   <= cnt + TMO_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_retune_regs.sv
module pll_retune_regs import pll_retune_pkg::*; #(
  parameter int L_W     = 16,
  parameter int A_W     = 16,
  parameter int TMO_W   = 8,
  parameter int TMO_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              commit,
  input  logic              tmo_hit,
  input  logic              req_q,
  input  logic              ack_s,
  output logic              start_req,
  output logic              clr_req,
  output logic              bypass_q,
  output logic              err_q,
  output logic [TMO_W-1:0]  tmo_lim,
  output logic [L_W-1:0]    stg_l,
  output logic [A_W-1:0]    stg_a,
  output logic [L_W-1:0]    act_l,
  output logic [A_W-1:0]    act_a
);
  logic wr_mode;
  logic unused_wbits;

  assign wr_mode      = bus_wr && (bus_addr == ADDR_MODE);
  assign start_req    = wr_mode &&  bus_wdata[BIT_REQ];
  assign clr_req      = wr_mode && !bus_wdata[BIT_REQ];
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_l    <= '0;
      stg_a    <= '0;
      act_l    <= '0;
      act_a    <= '0;
      bypass_q <= 1'b0;
      err_q    <= 1'b0;
      tmo_lim  <= TMO_W'(TMO_RST);
    end else begin
      if (wr_mode && !busy) bypass_q <= bus_wdata[BIT_BYP];

      if (tmo_hit)                           err_q <= 1'b1;
      else if (wr_mode && bus_wdata[BIT_ERR]) err_q <= 1'b0;

      if (!busy && bus_wr && (bus_addr == ADDR_STG_L)) stg_l <= bus_wdata[L_W-1:0];
      if (!busy && bus_wr && (bus_addr == ADDR_STG_A)) stg_a <= bus_wdata[A_W-1:0];

      if (commit) begin
        act_l <= stg_l;
        act_a <= stg_a;
      end

      if (bus_wr && (bus_addr == ADDR_TMO)) tmo_lim <= bus_wdata[TMO_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_MODE: begin
        bus_rdata[BIT_REQ] = req_q;
        bus_rdata[BIT_BYP] = bypass_q;
        bus_rdata[BIT_ERR] = err_q;
        bus_rdata[BIT_ACK] = ack_s;
      end
      ADDR_STG_L: bus_rdata = DW'(stg_l);
      ADDR_STG_A: bus_rdata = DW'(stg_a);
      ADDR_ACT_L: bus_rdata = DW'(act_l);
      ADDR_ACT_A: bus_rdata = DW'(act_a);
      ADDR_TMO:   bus_rdata = DW'(tmo_lim);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pll_retune_ctrl.sv
module pll_retune_ctrl import pll_retune_pkg::*; #(
  parameter int L_W        = 16,
  parameter int A_W        = 16,
  parameter int TMO_W      = 8,
  parameter int TMO_RST    = 64,
  parameter int MIN_WAIT   = 2,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              pll_run,
  input  logic              dyn_cap,
  input  logic              pll_ack,
  output logic              pll_latch,
  output logic [L_W-1:0]    pll_l,
  output logic [A_W-1:0]    pll_alpha
);
  upd_state_e       fsm_state;
  logic             ack_s;
  logic             run_ok;
  logic             start_req;
  logic             clr_req;
  logic             bypass_q;
  logic             err_q;
  logic             commit;
  logic             tmo_hit;
  logic             busy;
  logic [TMO_W-1:0] tmo_lim;
  logic [L_W-1:0]   act_l;
  logic [A_W-1:0]   act_a;

  assign run_ok = pll_run && dyn_cap;

  pll_ack_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pll_ack),
    .q_sync  (ack_s)
  );

  pll_retune_fsm #(.TMO_W(TMO_W), .MIN_WAIT(MIN_WAIT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .clr_req   (clr_req),
    .run_ok    (run_ok),
    .bypass    (bypass_q),
    .ack_s     (ack_s),
    .tmo_lim   (tmo_lim),
    .state     (fsm_state),
    .req_q     (pll_latch),
    .commit    (commit),
    .tmo_hit   (tmo_hit),
    .busy      (busy)
  );

  pll_retune_regs #(.L_W(L_W), .A_W(A_W), .TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .commit    (commit),
    .tmo_hit   (tmo_hit),
    .req_q     (pll_latch),
    .ack_s     (ack_s),
    .start_req (start_req),
    .clr_req   (clr_req),
    .bypass_q  (bypass_q),
    .err_q     (err_q),
    .tmo_lim   (tmo_lim),
    .stg_l     (pll_l),
    .stg_a     (pll_alpha),
    .act_l     (act_l),
    .act_a     (act_a)
  );
endmodule

// File: rtl/pll_retune_chk.sv
module pll_retune_chk import pll_retune_pkg::*; #(
  parameter int L_W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input upd_state_e     state,
  input logic           req_q,
  input logic           ack_s,
  input logic           tmo_hit,
  input logic           err,
  input logic           bypass,
  input logic           run_ok,
  input logic           clr_req,
  input logic [L_W-1:0] stg_l,
  input logic [L_W-1:0] act_l
);
  // R3
  idle_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !run_ok) |=> !req_q);

  // R4
  rise_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> (state == ST_WAIT_MIN));

  // R4
  min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_MIN) |=> $stable(act_l));

  // R5
  auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK_SET && ack_s && !bypass) |=> (!req_q && act_l == $past(stg_l)));

  // R6
  byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ_CLR && !clr_req) |=> (req_q && state == ST_REQ_CLR));

  // R7
  ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK_CLR && ack_s && !tmo_hit) |=> (state == ST_ACK_CLR));

  // R8
  tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (err && !req_q && state == ST_IDLE));

  // R9
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(stg_l));
endmodule

bind pll_retune_ctrl pll_retune_chk #(.L_W(L_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .state   (fsm_state),
  .req_q   (pll_latch),
  .ack_s   (ack_s),
  .tmo_hit (tmo_hit),
  .err     (err_q),
  .bypass  (bypass_q),
  .run_ok  (run_ok),
  .clr_req (clr_req),
  .stg_l   (pll_l),
  .act_l   (act_l)
);

// File: tb/test_pll_retune_ctrl.sv
module test_pll_retune_ctrl;
  import pll_retune_pkg::*;

  localparam int L_W = 16;
  localparam int A_W = 16;
  localparam int LIM = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [REG_AW-1:0] bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic              pll_run = 1'b1;
  logic              dyn_cap = 1'b1;
  logic              pll_ack = 1'b0;
  logic              pll_latch;
  logic [L_W-1:0]    pll_l;
  logic [A_W-1:0]    pll_alpha;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int rise_dly = 0;
  int fall_dly = 0;
  bit resp_on  = 1'b1;
  int hi_cnt   = 0;
  int lo_cnt   = 0;

  always #5 clk = ~clk;

  pll_retune_ctrl i_pll_retune_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pll_run   (pll_run),
    .dyn_cap   (dyn_cap),
    .pll_ack   (pll_ack),
    .pll_latch (pll_latch),
    .pll_l     (pll_l),
    .pll_alpha (pll_alpha)
  );

  // PLL responder: raise ack rise_dly cycles into the strobe, drop it after the strobe falls.
  always @(negedge clk) begin
    if (pll_latch) begin
      if (resp_on && hi_cnt == rise_dly) pll_ack = 1'b1;
      hi_cnt = hi_cnt + 1;
      lo_cnt = 0;
    end else begin
      hi_cnt = 0;
      if (resp_on && pll_ack) begin
        if (lo_cnt == fall_dly) pll_ack = 1'b0;
        lo_cnt = lo_cnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0]    v;
    logic [L_W-1:0] exp_l;
    logic [A_W-1:0] exp_a;
    logic [L_W-1:0] new_l;
    logic [A_W-1:0] new_a;
    bit             ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 latch", 32'(pll_latch), 32'd0);
    rd(ADDR_MODE, v);  check("R1 mode", v, 32'd0);
    rd(ADDR_ACT_L, v); check("R1 act L", v, 32'd0);
    rd(ADDR_ACT_A, v); check("R1 act alpha", v, 32'd0);
    rd(ADDR_TMO, v);   check("R1 timeout", v, 32'd64);
    exp_l = '0;
    exp_a = '0;

    wr(ADDR_TMO, 32'(LIM));
    rd(ADDR_TMO, v); check("R2 timeout readback", v, 32'(LIM));

    // R3 PLL not running
    pll_run = 1'b0;
    wr(ADDR_STG_L, 32'h0123);
    wr(ADDR_STG_A, 32'h4567);
    wr(ADDR_MODE, 32'(1) << BIT_REQ);
    check("R3 latch run off", 32'(pll_latch), 32'd0);
    repeat (8) @(negedge clk);
    rd(ADDR_MODE, v);  check("R3 req bit run off", (v >> BIT_REQ) & 32'd1, 32'd0);
    rd(ADDR_ACT_L, v); check("R3 act L run off", v, 32'(exp_l));
    rd(ADDR_STG_L, v); check("R2 staged L readback", v, 32'h0123);
    check("R2 pll_alpha port", 32'(pll_alpha), 32'h4567);
    pll_run = 1'b1;

    // R3 capability strap off
    dyn_cap = 1'b0;
    wr(ADDR_MODE, 32'(1) << BIT_REQ);
    check("R3 latch cap off", 32'(pll_latch), 32'd0);
    repeat (8) @(negedge clk);
    rd(ADDR_ACT_A, v); check("R3 act alpha cap off", v, 32'(exp_a));
    dyn_cap = 1'b1;

    // R7 start refused while synchronized ack is high
    resp_on = 1'b0;
    pll_ack = 1'b1;
    repeat (4) @(negedge clk);
    wr(ADDR_MODE, 32'(1) << BIT_REQ);
    check("R7 latch refused", 32'(pll_latch), 32'd0);
    rd(ADDR_MODE, v);
    check("R7 mode ack and req", v & ((32'd1 << BIT_ACK) | (32'd1 << BIT_REQ)), 32'd1 << BIT_ACK);
    pll_ack = 1'b0;
    repeat (4) @(negedge clk);
    resp_on = 1'b1;

    // Sweep of ack rise delay across the timeout, both bypass settings
    for (int byp = 0; byp < 2; byp++) begin
      for (int d = 0; d <= LIM + 1; d++) begin
        rise_dly = d;
        ok = (d <= LIM - 1);
        new_l = L_W'(16'h1000 + byp * 16 + d);
        new_a = A_W'(16'hA000 ^ (d << 4) ^ byp);
        wr(ADDR_STG_L, 32'(new_l));
        wr(ADDR_STG_A, 32'(new_a));
        wr(ADDR_MODE, (32'(1) << BIT_REQ) | (32'(byp) << BIT_BYP));
        check($sformatf("R4 latch up byp%0d d%0d", byp, d), 32'(pll_latch), 32'd1);
        rd(ADDR_ACT_L, v);
        check($sformatf("R4 no early update byp%0d d%0d", byp, d), v, 32'(exp_l));
        repeat (LIM + 8) @(negedge clk);
        if (ok) begin
          exp_l = new_l;
          exp_a = new_a;
        end
        if (ok && byp == 1) begin
          rd(ADDR_MODE, v);
          check($sformatf("R6 req held d%0d", d), (v >> BIT_REQ) & 32'd1, 32'd1);
          check($sformatf("R6 ack visible d%0d", d), (v >> BIT_ACK) & 32'd1, 32'd1);
          check($sformatf("R6 latch held d%0d", d), 32'(pll_latch), 32'd1);
          wr(ADDR_STG_L, 32'h5A5A);
          rd(ADDR_STG_L, v);
          check($sformatf("R9 staged write ignored d%0d", d), v, 32'(new_l));
          check($sformatf("R9 pll_l stable d%0d", d), 32'(pll_l), 32'(new_l));
          wr(ADDR_MODE, 32'(byp) << BIT_BYP);
        end else if (ok) begin
          rd(ADDR_MODE, v);
          check($sformatf("R5 req self clear d%0d", d), (v >> BIT_REQ) & 32'd1, 32'd0);
          check($sformatf("R5 latch low d%0d", d), 32'(pll_latch), 32'd0);
        end
        repeat (12) @(negedge clk);
        check($sformatf("R7 idle latch byp%0d d%0d", byp, d), 32'(pll_latch), 32'd0);
        rd(ADDR_ACT_L, v);
        check($sformatf("R5 R8 act L byp%0d d%0d", byp, d), v, 32'(exp_l));
        rd(ADDR_ACT_A, v);
        check($sformatf("R5 R8 act alpha byp%0d d%0d", byp, d), v, 32'(exp_a));
        rd(ADDR_MODE, v);
        check($sformatf("R8 error bit byp%0d d%0d", byp, d), (v >> BIT_ERR) & 32'd1, 32'(!ok));
        if (!ok) begin
          wr(ADDR_MODE, (32'(1) << BIT_ERR) | (32'(byp) << BIT_BYP));
          rd(ADDR_MODE, v);
          check($sformatf("R8 error clear byp%0d d%0d", byp, d), (v >> BIT_ERR) & 32'd1, 32'd0);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule